// File: doc/BRIEF.md
# Oversampled Serial Receiver with Address/Data Selector

This block takes one asynchronous serial line and turns it back into bytes. A free-running 16x oversample tick paces it. While enabled it waits for the line to drop low. It confirms the start bit half a bit later and then samples each following bit once, in the middle of its period. The byte arrives least significant bit first. In plain mode a ninth bit may carry parity, which is then checked. In multiprocessor mode the ninth bit is an address/data selector that is captured and never checked. A high stop bit closes the frame.

When a frame ends, the byte and the selector bit are placed in a holding register. The full flag and any error flags are raised in the same clock. The host reads the byte with a read strobe, which empties the holding register. The host clears the error flags with a separate clear strobe. An interrupt request follows the full flag whenever the interrupt enable is set.

Top module: `uart_mp_rx`

## Requirements
- R1: While `rx_en` is 0 the receiver stays idle. A complete frame on `rxd` then leaves `rx_full`, `rx_data` and all error flags unchanged.
- R2: A low level on the line starts a frame only if the line is still low half a bit period (8 ticks) later. A low pulse shorter than that is dropped, and the next real frame is received normally.
- R3: The eight data bits are taken least significant bit first, each sampled once at mid-bit. With `par_en`=0 and `mp_mode`=0 no ninth bit is expected, and `rx_adsel` reads 0.
- R4: With `par_en`=1 and `mp_mode`=0, a ninth bit follows the data as parity. With `par_odd`=0 the data plus parity must hold an even number of ones, and with `par_odd`=1 an odd number. A mismatch sets `err_par`.
- R5: With `mp_mode`=1, the ninth bit is stored in `rx_adsel` together with the byte, and `err_par` is never set, whatever `par_en` is.
- R6: A stop bit sampled low sets `err_frm`. The byte is still delivered and `rx_full` is still set.
- R7: At the end of each frame `rx_full` goes to 1 in the same clock as any error flag the frame raises. `rx_irq` is 1 exactly while `rx_full` and `rx_int_en` are both 1.
- R8: A frame that ends while `rx_full` is 1 (and no read strobe in that clock) sets `err_ovr` and keeps the earlier `rx_data` and `rx_adsel`. Its own parity and framing errors are still recorded.
- R9: `rd_strobe` clears `rx_full`, and `err_clr` clears all three error flags. Neither strobe changes `rx_data`. All error flags are sticky until `err_clr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_en | input | 1 | Receive enable |
| mp_mode | input | 1 | 1: ninth bit is address/data selector |
| par_en | input | 1 | 1: ninth bit is parity (plain mode) |
| par_odd | input | 1 | Parity sense: 0 even, 1 odd |
| rx_int_en | input | 1 | Receive interrupt enable |
| os_tick | input | 1 | Oversample tick, 16 per bit |
| rxd | input | 1 | Serial line, idles high |
| rd_strobe | input | 1 | Host read of the received byte |
| err_clr | input | 1 | Clears all error flags |
| rx_data | output | 8 | Held received byte |
| rx_adsel | output | 1 | Held address/data selector bit |
| rx_full | output | 1 | Holding register contains an unread byte |
| err_par | output | 1 | Parity error flag |
| err_frm | output | 1 | Framing error flag |
| err_ovr | output | 1 | Overrun error flag |
| rx_irq | output | 1 | Receive interrupt request |

## Verification
The line passes a two-flop synchronizer, so the stop bit is sampled about nine ticks after it begins. The flags follow two clocks after that sample. The bench holds every bit for exactly sixteen ticks and adds at least one idle bit before it looks at any flag, so every frame result is settled when it is sampled. The strobes act on the next clock edge, so the bench drives them for one cycle and checks one cycle later. `rx_irq` is combinational from the full flag and is checked in the same sample as `rx_full`.

// File: rtl/uart_mp_rx_pkg.sv
package uart_mp_rx_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_START,
      ST_DATA,
      ST_NINTH,
      ST_STOP
   } rx_state_e;

   typedef struct packed {
      logic par;
      logic frm;
   } frame_err_t;
endpackage

// File: rtl/uart_mp_rx_sync.sv
module uart_mp_rx_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   initial begin
      if (STAGES < 0 || STAGES > 4) $error("STAGES out of range");
   end

   generate
      if (STAGES == 0) begin : g_bypass
         assign q = d;
      end else begin : g_chain
         logic [STAGES-1:0] ff;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) ff <= '1;
            else begin
               ff[0] <= d;
               for (int i = 1; i < STAGES; i++) ff[i] <= ff[i-1];
            end
         end
         assign q = ff[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/uart_mp_rx_frame.sv
module uart_mp_rx_frame
   import uart_mp_rx_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int OSR    = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              tick,
   input  logic              line,
   input  logic              mp_mode,
   input  logic              par_en,
   input  logic              par_odd,
   output logic              done_o,
   output logic [DATA_W-1:0] data_o,
   output logic              xbit_o,
   output frame_err_t        err_o
);
   localparam int CW   = $clog2(OSR);
   localparam int BW   = $clog2(DATA_W + 1);
   localparam int HALF = OSR / 2;
   localparam logic [CW-1:0] CNT_LAST = CW'(OSR - 1);
   localparam logic [CW-1:0] CNT_MID  = CW'(HALF - 1);
   localparam logic [BW-1:0] BIT_LAST = BW'(DATA_W - 1);

   initial begin
      if (OSR < 4 || (OSR % 2) != 0) $error("OSR must be even and at least 4");
      if (DATA_W < 5 || DATA_W > 9) $error("DATA_W out of range");
   end

   rx_state_e         state;
   logic [CW-1:0]     cnt;
   logic [BW-1:0]     bidx;
   logic [DATA_W-1:0] shreg;
   logic              xreg;
   logic              ninth_en;
   logic              par_bad;

   assign ninth_en = mp_mode | par_en;
   assign par_bad  = par_en & ~mp_mode & ((^shreg ^ xreg) != par_odd);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         cnt    <= '0;
         bidx   <= '0;
         shreg  <= '0;
         xreg   <= 1'b0;
         done_o <= 1'b0;
         data_o <= '0;
         xbit_o <= 1'b0;
         err_o  <= '0;
      end else begin
         done_o <= 1'b0;
         if (!en) begin
            state <= ST_IDLE;
            cnt   <= '0;
         end else if (tick) begin
            unique case (state)
               ST_IDLE: begin
                  cnt <= '0;
                  if (!line) state <= ST_START;
               end
               ST_START: begin
                  if (cnt == CNT_MID) begin
                     cnt   <= '0;
                     bidx  <= '0;
                     state <= line ? ST_IDLE : ST_DATA;
                  end else cnt <= cnt + 1'b1;
               end
               ST_DATA: begin
                  if (cnt == CNT_LAST) begin
                     cnt   <= '0;
                     shreg <= {line, shreg[DATA_W-1:1]};
                     bidx  <= bidx + 1'b1;
                     if (bidx == BIT_LAST) state <= ninth_en ? ST_NINTH : ST_STOP;
                  end else cnt <= cnt + 1'b1;
               end
               ST_NINTH: begin
                  if (cnt == CNT_LAST) begin
                     cnt   <= '0;
                     xreg  <= line;
                     state <= ST_STOP;
                  end else cnt <= cnt + 1'b1;
               end
               ST_STOP: begin
                  if (cnt == CNT_LAST) begin
                     cnt       <= '0;
                     done_o    <= 1'b1;
                     data_o    <= shreg;
                     xbit_o    <= mp_mode & xreg;
                     err_o.frm <= ~line;
                     err_o.par <= par_bad;
                     state     <= ST_IDLE;
                  end else cnt <= cnt + 1'b1;
               end
               default: state <= ST_IDLE;
            endcase
         end
      end
   end

   AST_OFF_GOES_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> state == ST_IDLE);  // R1
   AST_BIT_INDEX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      bidx <= BW'(DATA_W));  // R3
   AST_DONE_FROM_STOP: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> $past(state) == ST_STOP);  // R7
   AST_START_NEEDS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_START && tick && en && cnt == CNT_MID && line) |=> state == ST_IDLE);  // R2
endmodule

// File: rtl/uart_mp_rx_hold.sv
module uart_mp_rx_hold
   import uart_mp_rx_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              done_i,
   input  logic [DATA_W-1:0] data_i,
   input  logic              xbit_i,
   input  frame_err_t        err_i,
   input  logic              rd_i,
   input  logic              clr_i,
   output logic [DATA_W-1:0] data_o,
   output logic              xbit_o,
   output logic              full_o,
   output logic              e_par_o,
   output logic              e_frm_o,
   output logic              e_ovr_o
);
   logic overrun;
   assign overrun = done_i & full_o & ~rd_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_o  <= '0;
         xbit_o  <= 1'b0;
         full_o  <= 1'b0;
         e_par_o <= 1'b0;
         e_frm_o <= 1'b0;
         e_ovr_o <= 1'b0;
      end else begin
         if (rd_i) full_o <= 1'b0;
         if (clr_i) begin
            e_par_o <= 1'b0;
            e_frm_o <= 1'b0;
            e_ovr_o <= 1'b0;
         end
         if (done_i) begin
            full_o <= 1'b1;
            if (overrun) e_ovr_o <= 1'b1;
            else begin
               data_o <= data_i;
               xbit_o <= xbit_i;
            end
            if (err_i.par) e_par_o <= 1'b1;
            if (err_i.frm) e_frm_o <= 1'b1;
         end
      end
   end

   AST_FULL_AFTER_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
      done_i |=> full_o);  // R7
   AST_FULL_ONLY_FROM_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(full_o) |-> $past(done_i));  // R7
   AST_OVERRUN_KEEPS_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
      (done_i && full_o && !rd_i) |=> (e_ovr_o && $stable(data_o)));  // R8
   AST_READ_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_i && !done_i) |=> !full_o);  // R9
   AST_CLEAR_ERRORS: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && !done_i) |=> !(e_par_o || e_frm_o || e_ovr_o));  // R9
endmodule

// File: rtl/uart_mp_rx.sv
module uart_mp_rx
   import uart_mp_rx_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int OSR         = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_en,
   input  logic              mp_mode,
   input  logic              par_en,
   input  logic              par_odd,
   input  logic              rx_int_en,
   input  logic              os_tick,
   input  logic              rxd,
   input  logic              rd_strobe,
   input  logic              err_clr,
   output logic [DATA_W-1:0] rx_data,
   output logic              rx_adsel,
   output logic              rx_full,
   output logic              err_par,
   output logic              err_frm,
   output logic              err_ovr,
   output logic              rx_irq
);
   logic              line_s;
   logic              done;
   logic [DATA_W-1:0] f_data;
   logic              f_xbit;
   frame_err_t        f_err;

   uart_mp_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(rxd), .q(line_s)
   );

   uart_mp_rx_frame #(.DATA_W(DATA_W), .OSR(OSR)) u_frame (
      .clk(clk), .rst_n(rst_n), .en(rx_en), .tick(os_tick), .line(line_s),
      .mp_mode(mp_mode), .par_en(par_en), .par_odd(par_odd),
      .done_o(done), .data_o(f_data), .xbit_o(f_xbit), .err_o(f_err)
   );

   uart_mp_rx_hold #(.DATA_W(DATA_W)) u_hold (
      .clk(clk), .rst_n(rst_n), .done_i(done), .data_i(f_data), .xbit_i(f_xbit),
      .err_i(f_err), .rd_i(rd_strobe), .clr_i(err_clr),
      .data_o(rx_data), .xbit_o(rx_adsel), .full_o(rx_full),
      .e_par_o(err_par), .e_frm_o(err_frm), .e_ovr_o(err_ovr)
   );

   assign rx_irq = rx_full & rx_int_en;

   AST_MP_NO_PARITY: assert property (@(posedge clk) disable iff (!rst_n)
      (done && $past(mp_mode)) |-> !f_err.par);  // R5
   AST_OFF_NO_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
      (!rx_en && !$past(rx_en)) |-> !done);  // R1
endmodule

// File: tb/uart_mp_rx_bench.sv
module uart_mp_rx_bench;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic rx_en = 1'b0, mp_mode = 1'b0, par_en = 1'b0, par_odd = 1'b0, rx_int_en = 1'b0;
   logic rxd = 1'b1, rd_strobe = 1'b0, err_clr = 1'b0;
   logic [1:0] tdiv = 2'd0;
   logic os_tick;
   logic [7:0] rx_data;
   logic rx_adsel, rx_full, err_par, err_frm, err_ovr, rx_irq;

   int nchk = 0;
   int nfail = 0;

   logic [7:0] m_data = 8'h00;
   logic m_adsel = 1'b0, m_full = 1'b0, m_par = 1'b0, m_frm = 1'b0, m_ovr = 1'b0;

   always #5 clk = ~clk;
   always @(posedge clk) tdiv <= (tdiv == 2'd2) ? 2'd0 : tdiv + 2'd1;
   assign os_tick = (tdiv == 2'd0);

   uart_mp_rx u_uart_mp_rx (
      .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .mp_mode(mp_mode), .par_en(par_en),
      .par_odd(par_odd), .rx_int_en(rx_int_en), .os_tick(os_tick), .rxd(rxd),
      .rd_strobe(rd_strobe), .err_clr(err_clr), .rx_data(rx_data), .rx_adsel(rx_adsel),
      .rx_full(rx_full), .err_par(err_par), .err_frm(err_frm), .err_ovr(err_ovr),
      .rx_irq(rx_irq)
   );

   task automatic chk(input string req, input string what, input logic [31:0] act,
                      input logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic chk_all(input string req);
      chk(req, "rx_data", {24'd0, rx_data}, {24'd0, m_data});
      chk(req, "rx_adsel", {31'd0, rx_adsel}, {31'd0, m_adsel});
      chk(req, "rx_full", {31'd0, rx_full}, {31'd0, m_full});
      chk(req, "err_par", {31'd0, err_par}, {31'd0, m_par});
      chk(req, "err_frm", {31'd0, err_frm}, {31'd0, m_frm});
      chk(req, "err_ovr", {31'd0, err_ovr}, {31'd0, m_ovr});
      chk(req, "rx_irq", {31'd0, rx_irq}, {31'd0, m_full & rx_int_en});
   endtask

   task automatic hold(input logic v, input int ticks);
      rxd = v;
      repeat (ticks * 3) @(negedge clk);
   endtask

   // one frame on the line plus the bench's own expectation of its result
   task automatic send_frame(input logic [7:0] d, input logic xb, input logic stop_ok);
      logic ninth, pbad;
      ninth = mp_mode | par_en;
      pbad  = par_en & ~mp_mode & ((^d ^ xb) != par_odd);
      hold(1'b0, 16);
      for (int i = 0; i < 8; i++) hold(d[i], 16);
      if (ninth) hold(xb, 16);
      if (stop_ok) hold(1'b1, 16);
      else begin
         hold(1'b0, 11);
         hold(1'b1, 5);
      end
      hold(1'b1, 16);
      if (!stop_ok) hold(1'b1, 24);
      if (rx_en) begin
         if (m_full) m_ovr = 1'b1;
         else begin
            m_data  = d;
            m_adsel = mp_mode & xb;
         end
         m_full = 1'b1;
         if (pbad) m_par = 1'b1;
         if (!stop_ok) m_frm = 1'b1;
      end
   endtask

   task automatic do_read();
      @(negedge clk) rd_strobe = 1'b1;
      @(negedge clk) rd_strobe = 1'b0;
      m_full = 1'b0;
   endtask

   task automatic do_clear();
      @(negedge clk) err_clr = 1'b1;
      @(negedge clk) err_clr = 1'b0;
      m_par = 1'b0; m_frm = 1'b0; m_ovr = 1'b0;
   endtask

   function automatic logic [7:0] pick(input int k);
      if (k == 0) return 8'h00;
      if (k == 1) return 8'hFF;
      return 8'(k * 75) ^ 8'h96;
   endfunction

   task automatic finish_run();
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      nfail++;
      $display("FAIL watchdog run did not complete");
      finish_run();
   end

   initial begin
      repeat (5) @(negedge clk);
      chk_all("R7 reset");
      rst_n = 1'b1;
      rx_int_en = 1'b1;

      // R1: disabled receiver ignores a whole frame
      hold(1'b1, 16);
      send_frame(8'h3C, 1'b0, 1'b1);
      chk_all("R1 disabled");
      rx_en = 1'b1;
      hold(1'b1, 16);

      // sweep of modes, bytes and ninth-bit values
      for (int cfg = 0; cfg < 4; cfg++) begin
         mp_mode = (cfg == 3);
         par_en  = (cfg != 0);
         par_odd = (cfg == 2);
         for (int k = 0; k < 8; k++) begin
            for (int x = 0; x < 2; x++) begin
               if (cfg == 0 && x == 1) continue;
               send_frame(pick(k), x[0], 1'b1);
               if (cfg == 0) chk_all("R3 plain byte");
               else if (cfg == 3) chk_all("R5 selector bit");
               else chk_all("R4 parity");
               do_read();
               do_clear();
               chk_all("R9 read and clear");
            end
         end
      end

      // R6: low stop bit
      mp_mode = 1'b0; par_en = 1'b0; par_odd = 1'b0;
      send_frame(8'hC3, 1'b0, 1'b0);
      chk_all("R6 framing");
      do_read();
      chk_all("R9 read keeps errors");
      do_clear();

      // R8: overrun keeps first byte
      send_frame(8'h11, 1'b0, 1'b1);
      send_frame(8'h22, 1'b0, 1'b1);
      chk_all("R8 overrun");
      chk("R8", "rx_data kept", {24'd0, rx_data}, 32'h11);
      rx_int_en = 1'b0;
      @(negedge clk);
      chk_all("R7 irq masked");
      rx_int_en = 1'b1;
      do_read();
      chk_all("R9 read after overrun");
      do_clear();
      chk_all("R9 clear after overrun");

      // R2: short low pulse is dropped, next frame is fine
      hold(1'b0, 4);
      hold(1'b1, 32);
      chk_all("R2 glitch ignored");
      send_frame(8'hA7, 1'b0, 1'b1);
      chk_all("R2 frame after glitch");
      do_read();

      // R5: multiprocessor mode with a parity-breaking selector value
      mp_mode = 1'b1; par_en = 1'b1; par_odd = 1'b0;
      send_frame(8'h01, 1'b0, 1'b1);
      chk_all("R5 no parity check");
      chk("R5", "err_par", {31'd0, err_par}, 32'd0);

      // R1: disable while full, then a frame leaves everything unchanged
      rx_en = 1'b0;
      send_frame(8'h5E, 1'b1, 1'b0);
      chk_all("R1 disabled while full");

      finish_run();
   end
endmodule